// File: doc/BRIEF.md
# Palette lookup with colour cycling

This block turns a stream of 8-bit colour indices into 12-bit RGB pixels for a 640x480, 60 Hz raster. A 256-entry palette store sits inside the block. Software never writes entries directly. It writes a base address, and the block then reads 256 consecutive words from the attached video RAM and fills entries 0 to 255 in order. Because the store is refilled while pixels keep flowing, a base write made during active video changes the colours of the pixels that follow. This is what lets software retune the palette part way down the screen.

A rotation engine shifts the colours of a chosen index window without moving any palette data. The engine keeps an offset register, and an incoming index that falls inside the window is remapped through that offset before the lookup. The offset moves on by one after a programmed number of frames, counted on a frame pulse given at the start of vertical blanking. Each lookup takes two pixel clocks. Blanking and valid travel alongside the data, and the colour is forced to black while blanking is set.

Top module: `cyc_palette`

## Requirements
- R1: `rgb_valid` equals `pix_valid` delayed by exactly two clocks. When that pixel was valid and not blanked, `rgb` then holds the palette entry for the remapped index of the pixel presented two clocks earlier.
- R2: A pixel presented with `pix_blank` high comes out two clocks later with `rgb` equal to zero.
- R3: A palette entry is the 12-bit word read from video RAM. Red is in bits 11:8, green in bits 7:4 and blue in bits 3:0, and `rgb` uses the same layout.
- R4: A write with `cfg_sel` = 0 sets the base address B and starts a fill. The block requests the words at B+k, taken modulo 2^ADDR_W, for k = 0 to 255 in ascending order. The k-th returned word loads entry k. A pending request keeps its address until it is granted.
- R5: A base write made while a fill is in progress stops new requests from the next clock. Returns still owed to the abandoned fill are discarded. Once nothing is outstanding, a fresh fill starts from the newest base.
- R6: An entry written in clock w is seen by pixels presented after clock w. A pixel presented in clock w still reads the previous value of that entry.
- R7: The window is set by writes with `cfg_sel` = 1 (first index F) and `cfg_sel` = 2 (last index L). When F ≤ L, an index i with F ≤ i ≤ L looks up entry F + ((i − F + off) mod (L − F + 1)).
- R8: An index outside [F, L] is looked up unchanged. When F > L, the window is empty and every index is looked up unchanged.
- R9: With rate N > 0, written with `cfg_sel` = 3, the offset advances by one on every N-th `frame_tick` pulse and wraps from L − F to 0. It changes at no other time.
- R10: A rate of zero, or an empty window, holds the offset at zero. Any write with `cfg_sel` of 1, 2 or 3 clears the offset and the frame count.
- R11: During reset and until the first base write, no video RAM request is made. During reset, `rgb` and `rgb_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 first index, 2 last index, 3 rate |
| cfg_wdata | input | ADDR_W | Write data, low bits used for index and rate registers |
| frame_tick | input | 1 | One-clock pulse at the start of vertical blanking |
| pix_valid | input | 1 | Pixel index valid |
| pix_blank | input | 1 | Pixel lies in blanking |
| pix_index | input | IDX_W | Palette index of the pixel |
| vram_rd_req | output | 1 | Read request to video RAM |
| vram_rd_addr | output | ADDR_W | Word address of the request |
| vram_rd_gnt | input | 1 | Request accepted this clock |
| vram_rd_valid | input | 1 | Read data returned this clock, in request order |
| vram_rd_data | input | DATA_W | Returned colour word |
| rgb_valid | output | 1 | Output pixel valid |
| rgb | output | DATA_W | Output colour, red 11:8, green 7:4, blue 3:0 |

## Verification
A corrupted rotation offset or frame count shows up on the first pixel of the window after a frame pulse, because the remapped colour differs from the one predicted by the arithmetic. A fill counter that is off by one, or a return that should have been dropped after a restart, leaves wrong colours in entries that a full 256-index sweep exposes a few clocks after the fill ends. A pipeline stage that is missing or doubled shifts `rgb_valid` and the blank forcing against the pixel stream, so the very next pixel disagrees.

// File: rtl/cyc_palette_pkg.sv
package cyc_palette_pkg;

  // Register select codes on the configuration port.
  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_FIRST = 2'd1,
    SEL_LAST  = 2'd2,
    SEL_RATE  = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/cyc_store.sv
// Palette storage: one synchronous write port, one registered read port.
// A read and a write to the same entry in one clock return the old value.
module cyc_store #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
    rd_data <= mem[rd_idx];
  end

endmodule

// File: rtl/cyc_rotor.sv
// Rotation engine: keeps a frame-paced offset and remaps indices that
// fall inside the programmed window.
module cyc_rotor #(
  parameter int IDX_W  = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  first,
  input  logic [IDX_W-1:0]  last,
  input  logic [RATE_W-1:0] rate,
  input  logic              cfg_clear,
  input  logic              frame_tick,
  input  logic [IDX_W-1:0]  idx_in,
  output logic [IDX_W-1:0]  idx_out,
  output logic [IDX_W:0]    offset
);
  localparam int SPAN_W = IDX_W + 1;

  logic              win_ok;
  logic [SPAN_W-1:0] span;
  logic              in_win;
  logic [SPAN_W-1:0] rel;
  logic [SPAN_W-1:0] sum;
  logic [SPAN_W-1:0] wrapped;
  logic [SPAN_W-1:0] off_inc;
  logic [RATE_W:0]   fc_inc;
  logic [RATE_W-1:0] fcnt;

  assign win_ok  = (first <= last);
  assign span    = {1'b0, last} - {1'b0, first} + SPAN_W'(1);
  assign in_win  = win_ok && (idx_in >= first) && (idx_in <= last);
  assign rel     = {1'b0, idx_in} - {1'b0, first};
  assign sum     = rel + offset;
  assign wrapped = (sum >= span) ? (sum - span) : sum;
  assign idx_out = in_win ? (first + wrapped[IDX_W-1:0]) : idx_in;

  assign off_inc = offset + SPAN_W'(1);
  assign fc_inc  = {1'b0, fcnt} + (RATE_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst || cfg_clear || (rate == '0) || !win_ok) begin
      offset <= '0;
      fcnt   <= '0;
    end else if (frame_tick) begin
      if (fc_inc >= {1'b0, rate}) begin
        fcnt   <= '0;
        offset <= (off_inc >= span) ? '0 : off_inc;
      end else begin
        fcnt   <= fc_inc[RATE_W-1:0];
      end
    end
  end

endmodule

// File: rtl/cyc_fetch.sv
// Fill sequencer: reads one full palette from video RAM at a latched base,
// in order, and restarts cleanly when a new base arrives mid-fill.
module cyc_fetch #(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 17,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [ADDR_W-1:0] base,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_gnt,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int CNT_W   = IDX_W + 1;
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(ENTRIES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ENTRIES - 1);

  logic              busy;
  logic              pend;
  logic [CNT_W-1:0]  req_cnt;
  logic [CNT_W-1:0]  ret_cnt;
  logic [CNT_W-1:0]  outst;
  logic [ADDR_W-1:0] cur_base;
  logic              issue;
  logic              accept;
  logic              retire;

  assign rd_req  = busy && !pend && (req_cnt < CNT_END);
  assign rd_addr = cur_base + ADDR_W'(req_cnt);
  assign issue   = rd_req && rd_gnt;
  assign retire  = rd_valid && (outst != '0);
  assign accept  = rd_valid && busy && !pend && (ret_cnt < CNT_END);

  assign wr_en   = accept;
  assign wr_idx  = ret_cnt[IDX_W-1:0];
  assign wr_data = rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      outst <= '0;
    end else begin
      outst <= outst + CNT_W'(issue) - CNT_W'(retire);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      pend     <= 1'b0;
      req_cnt  <= '0;
      ret_cnt  <= '0;
      cur_base <= '0;
    end else begin
      if (issue) begin
        req_cnt <= req_cnt + CNT_W'(1);
      end
      if (accept) begin
        ret_cnt <= ret_cnt + CNT_W'(1);
        if (ret_cnt == CNT_LAST) begin
          busy <= 1'b0;
        end
      end
      if (launch) begin
        pend <= 1'b1;
      end else if (pend && (outst == '0)) begin
        pend     <= 1'b0;
        busy     <= 1'b1;
        req_cnt  <= '0;
        ret_cnt  <= '0;
        cur_base <= base;
      end
    end
  end

endmodule

// File: rtl/cyc_palette.sv
// Palette lookup with frame-paced colour rotation and video RAM refill.
module cyc_palette
  import cyc_palette_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 12,
  parameter int ADDR_W = 17,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              frame_tick,
  input  logic              pix_valid,
  input  logic              pix_blank,
  input  logic [IDX_W-1:0]  pix_index,
  output logic              vram_rd_req,
  output logic [ADDR_W-1:0] vram_rd_addr,
  input  logic              vram_rd_gnt,
  input  logic              vram_rd_valid,
  input  logic [DATA_W-1:0] vram_rd_data,
  output logic              rgb_valid,
  output logic [DATA_W-1:0] rgb
);
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  first_q;
  logic [IDX_W-1:0]  last_q;
  logic [RATE_W-1:0] rate_q;
  logic              launch;
  logic              cfg_clear;
  logic [IDX_W-1:0]  mapped_idx;
  logic [IDX_W:0]    rot_offset;
  logic              st_wr_en;
  logic [IDX_W-1:0]  st_wr_idx;
  logic [DATA_W-1:0] st_wr_data;
  logic [DATA_W-1:0] st_rd_data;
  logic              s1_valid;
  logic              s1_blank;

  assign launch    = cfg_we && (cfg_sel == SEL_BASE);
  assign cfg_clear = cfg_we && (cfg_sel != SEL_BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      first_q <= '0;
      last_q  <= '0;
      rate_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_BASE:  base_q  <= cfg_wdata;
        SEL_FIRST: first_q <= cfg_wdata[IDX_W-1:0];
        SEL_LAST:  last_q  <= cfg_wdata[IDX_W-1:0];
        default:   rate_q  <= cfg_wdata[RATE_W-1:0];
      endcase
    end
  end

  cyc_fetch #(
    .IDX_W (IDX_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_fetch (
    .clk     (clk),
    .rst     (rst),
    .launch  (launch),
    .base    (base_q),
    .rd_req  (vram_rd_req),
    .rd_addr (vram_rd_addr),
    .rd_gnt  (vram_rd_gnt),
    .rd_valid(vram_rd_valid),
    .rd_data (vram_rd_data),
    .wr_en   (st_wr_en),
    .wr_idx  (st_wr_idx),
    .wr_data (st_wr_data)
  );

  cyc_rotor #(
    .IDX_W (IDX_W),
    .RATE_W(RATE_W)
  ) u_rot (
    .clk       (clk),
    .rst       (rst),
    .first     (first_q),
    .last      (last_q),
    .rate      (rate_q),
    .cfg_clear (cfg_clear),
    .frame_tick(frame_tick),
    .idx_in    (pix_index),
    .idx_out   (mapped_idx),
    .offset    (rot_offset)
  );

  cyc_store #(
    .IDX_W (IDX_W),
    .DATA_W(DATA_W)
  ) u_store (
    .clk    (clk),
    .wr_en  (st_wr_en),
    .wr_idx (st_wr_idx),
    .wr_data(st_wr_data),
    .rd_idx (mapped_idx),
    .rd_data(st_rd_data)
  );

  // Stage 1 runs beside the store read; stage 2 is the output register.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_blank  <= 1'b0;
      rgb_valid <= 1'b0;
      rgb       <= '0;
    end else begin
      s1_valid  <= pix_valid;
      s1_blank  <= pix_blank;
      rgb_valid <= s1_valid;
      rgb       <= (s1_valid && !s1_blank) ? st_rd_data : '0;
    end
  end

endmodule

// File: rtl/cyc_palette_chk.sv
module cyc_palette_chk #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 12,
  parameter int ADDR_W = 17,
  parameter int RATE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic              frame_tick,
  input logic              pix_valid,
  input logic              pix_blank,
  input logic [IDX_W-1:0]  pix_index,
  input logic              vram_rd_req,
  input logic [ADDR_W-1:0] vram_rd_addr,
  input logic              vram_rd_gnt,
  input logic              rgb_valid,
  input logic [DATA_W-1:0] rgb,
  input logic [IDX_W-1:0]  first_q,
  input logic [IDX_W-1:0]  last_q,
  input logic [RATE_W-1:0] rate_q,
  input logic [IDX_W-1:0]  mapped_idx,
  input logic [IDX_W:0]    rot_offset
);
  logic [1:0] age;
  logic       base_wr;

  assign base_wr = cfg_we && (cfg_sel == 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      age <= '0;
    end else if (age != 2'd3) begin
      age <= age + 2'd1;
    end
  end

  a_r1_valid_delay: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (rgb_valid == $past(pix_valid, 2)));

  a_r2_blank_black: assert property (@(posedge clk) disable iff (rst)
    ((age >= 2'd2) && $past(pix_blank, 2)) |-> (rgb == '0));

  a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (vram_rd_req && !vram_rd_gnt && !base_wr) |=> (vram_rd_req && $stable(vram_rd_addr)));

  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    (vram_rd_req && vram_rd_gnt) |=>
      (!vram_rd_req || (vram_rd_addr == $past(vram_rd_addr) + ADDR_W'(1))));

  a_r5_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    base_wr |=> !vram_rd_req);

  a_r7_stay_inside: assert property (@(posedge clk) disable iff (rst)
    ((first_q <= last_q) && (pix_index >= first_q) && (pix_index <= last_q)) |->
      ((mapped_idx >= first_q) && (mapped_idx <= last_q)));

  a_r8_pass_outside: assert property (@(posedge clk) disable iff (rst)
    ((first_q > last_q) || (pix_index < first_q) || (pix_index > last_q)) |->
      (mapped_idx == pix_index));

  a_r9_offset_hold: assert property (@(posedge clk) disable iff (rst)
    (!frame_tick && !cfg_we) |=> $stable(rot_offset));

  a_r10_zero_rate: assert property (@(posedge clk) disable iff (rst)
    (rate_q == '0) |=> (rot_offset == '0));

  a_r11_reset_quiet: assert property (@(posedge clk)
    rst |=> (!vram_rd_req && !rgb_valid && (rgb == '0)));

endmodule

bind cyc_palette cyc_palette_chk #(
  .IDX_W (IDX_W),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .RATE_W(RATE_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .frame_tick  (frame_tick),
  .pix_valid   (pix_valid),
  .pix_blank   (pix_blank),
  .pix_index   (pix_index),
  .vram_rd_req (vram_rd_req),
  .vram_rd_addr(vram_rd_addr),
  .vram_rd_gnt (vram_rd_gnt),
  .rgb_valid   (rgb_valid),
  .rgb         (rgb),
  .first_q     (first_q),
  .last_q      (last_q),
  .rate_q      (rate_q),
  .mapped_idx  (mapped_idx),
  .rot_offset  (rot_offset)
);

// File: tb/cyc_palette_tb_top.sv
`timescale 1ns/1ps
module cyc_palette_tb_top;
  localparam int IDX_W  = 8;
  localparam int DATA_W = 12;
  localparam int ADDR_W = 17;
  localparam int RATE_W = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic              cfg_we;
  logic [1:0]        cfg_sel;
  logic [ADDR_W-1:0] cfg_wdata;
  logic              frame_tick;
  logic              pix_valid;
  logic              pix_blank;
  logic [IDX_W-1:0]  pix_index;
  logic              vram_rd_req;
  logic [ADDR_W-1:0] vram_rd_addr;
  logic              vram_rd_gnt;
  logic              vram_rd_valid;
  logic [DATA_W-1:0] vram_rd_data;
  logic              rgb_valid;
  logic [DATA_W-1:0] rgb;

  always #2 clk = ~clk;

  cyc_palette #(
    .IDX_W (IDX_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .RATE_W(RATE_W)
  ) dut_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .frame_tick   (frame_tick),
    .pix_valid    (pix_valid),
    .pix_blank    (pix_blank),
    .pix_index    (pix_index),
    .vram_rd_req  (vram_rd_req),
    .vram_rd_addr (vram_rd_addr),
    .vram_rd_gnt  (vram_rd_gnt),
    .vram_rd_valid(vram_rd_valid),
    .vram_rd_data (vram_rd_data),
    .rgb_valid    (rgb_valid),
    .rgb          (rgb)
  );

  // Video RAM model: automatic responder or hand-driven from the main flow.
  logic              manual = 1'b0;
  logic              auto_gnt = 1'b0, auto_valid = 1'b0;
  logic [DATA_W-1:0] auto_data = '0;
  logic              man_gnt = 1'b0, man_valid = 1'b0;
  logic [DATA_W-1:0] man_data = '0;
  logic              lq_v [3];
  logic [ADDR_W-1:0] lq_a [3];
  int                rsp_cnt = 0;

  assign vram_rd_gnt   = manual ? man_gnt   : auto_gnt;
  assign vram_rd_valid = manual ? man_valid : auto_valid;
  assign vram_rd_data  = manual ? man_data  : auto_data;

  function automatic logic [DATA_W-1:0] vw(input logic [ADDR_W-1:0] a);
    logic [11:0] t;
    t = a[11:0] * 12'd37 + 12'd1443;
    return t ^ {5'd0, a[16:10]};
  endfunction

  initial begin
    for (int i = 0; i < 3; i++) begin
      lq_v[i] = 1'b0;
      lq_a[i] = '0;
    end
  end

  always @(negedge clk) begin
    rsp_cnt = rsp_cnt + 1;
    if (rst || manual) begin
      auto_gnt   = 1'b0;
      auto_valid = 1'b0;
      for (int i = 0; i < 3; i++) lq_v[i] = 1'b0;
    end else begin
      auto_valid = lq_v[2];
      auto_data  = vw(lq_a[2]);
      lq_v[2] = lq_v[1]; lq_a[2] = lq_a[1];
      lq_v[1] = lq_v[0]; lq_a[1] = lq_a[0];
      auto_gnt = vram_rd_req && ((rsp_cnt % 3) != 2);
      lq_v[0] = auto_gnt;
      lq_a[0] = vram_rd_addr;
    end
  end

  // Bench bookkeeping and model state.
  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] pal [256];
  int m_first = 0, m_last = 0, m_rate = 0, m_off = 0, m_fc = 0;

  logic              hv [2];
  bit                hc [2];
  logic [DATA_W-1:0] he [2];
  string             ht [2];

  function automatic int map_idx(input int i);
    if (m_first <= m_last && i >= m_first && i <= m_last)
      return m_first + ((i - m_first + m_off) % (m_last - m_first + 1));
    return i;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: compare the output owed from two clocks ago, then drive.
  task automatic step(input logic v, input logic b, input int idx,
                      input logic [DATA_W-1:0] e, input bit c, input string tag);
    @(negedge clk);
    chk(rgb_valid === hv[1], "R1 valid delay", int'(rgb_valid), int'(hv[1]));
    if (hc[1]) chk(rgb === he[1], ht[1], int'(rgb), int'(he[1]));
    hv[1] = hv[0]; hc[1] = hc[0]; he[1] = he[0]; ht[1] = ht[0];
    hv[0] = v;     hc[0] = c;     he[0] = e;     ht[0] = tag;
    pix_valid = v;
    pix_blank = b;
    pix_index = IDX_W'(idx);
  endtask

  task automatic idle(input int n);
    repeat (n) step(1'b0, 1'b0, 0, '0, 1'b0, "");
  endtask

  task automatic sweep(input int lo, input int hi, input string tag);
    for (int i = lo; i <= hi; i++) step(1'b1, 1'b0, i, pal[map_idx(i)], 1'b1, tag);
  endtask

  task automatic cfg(input int sel, input int val);
    cfg_we    = 1'b1;
    cfg_sel   = 2'(sel);
    cfg_wdata = ADDR_W'(val);
    idle(1);
    cfg_we = 1'b0;
    if (sel == 1) m_first = val;
    if (sel == 2) m_last  = val;
    if (sel == 3) m_rate  = val;
    if (sel != 0) begin
      m_off = 0;
      m_fc  = 0;
    end
  endtask

  task automatic tick();
    frame_tick = 1'b1;
    idle(1);
    frame_tick = 1'b0;
    if (m_rate == 0 || m_first > m_last) begin
      m_off = 0;
      m_fc  = 0;
    end else if (m_fc + 1 >= m_rate) begin
      m_fc  = 0;
      m_off = (m_off + 1 >= m_last - m_first + 1) ? 0 : m_off + 1;
    end else begin
      m_fc = m_fc + 1;
    end
  endtask

  task automatic load(input int base, input int wait_n);
    cfg(0, base);
    idle(wait_n);
    for (int k = 0; k < 256; k++) pal[k] = vw(ADDR_W'(base + k));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      hv[i] = 1'b0; hc[i] = 1'b0; he[i] = '0; ht[i] = "";
    end
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    frame_tick = 1'b0; pix_valid = 1'b0; pix_blank = 1'b0; pix_index = '0;
    repeat (4) @(negedge clk);
    // R11: quiet outputs during reset
    chk(rgb == '0, "R11 rgb in reset", int'(rgb), 0);
    chk(rgb_valid == 1'b0, "R11 valid in reset", int'(rgb_valid), 0);
    chk(vram_rd_req == 1'b0, "R11 req in reset", int'(vram_rd_req), 0);
    rst = 1'b0;
    idle(10);
    chk(vram_rd_req == 1'b0, "R11 no req before base write", int'(vram_rd_req), 0);

    // R4 / R3: full fill from a base that wraps past the top of the address space
    load(17'h1FF80, 700);
    sweep(0, 255, "R4 fill with address wrap");
    sweep(0, 15, "R3 colour word layout");

    // R2: blanking forces black, mixed with visible pixels
    for (int i = 0; i < 64; i++) begin
      if (i % 2 == 0) step(1'b1, 1'b1, i, '0, 1'b1, "R2 blank forced");
      else            step(1'b1, 1'b0, i, pal[i], 1'b1, "R2 visible next to blank");
    end

    // R5: restart mid-fill, only the newest base must survive
    cfg(0, 17'h00400);
    idle(30);
    load(17'h02A00, 800);
    sweep(0, 255, "R5 restart keeps newest base");

    // R6: entry updates take effect on the following pixel
    manual = 1'b1;
    cfg(0, 17'h05000);
    for (int k = 0; k < 6; k++) begin
      int guard;
      logic [ADDR_W-1:0] a;
      guard = 0;
      while (!vram_rd_req && guard < 50) begin
        idle(1);
        guard++;
      end
      chk(vram_rd_addr == ADDR_W'(17'h05000 + k), "R4 request order",
          int'(vram_rd_addr), 17'h05000 + k);
      a = vram_rd_addr;
      man_gnt = 1'b1;
      idle(1);
      man_gnt = 1'b0;
      step(1'b1, 1'b0, k, pal[k], 1'b1, "R6 same-clock read sees old");
      man_valid = 1'b1;
      man_data  = vw(a);
      step(1'b1, 1'b0, k, vw(a), 1'b1, "R6 next pixel sees new");
      man_valid = 1'b0;
    end
    manual = 1'b0;
    idle(800);
    for (int k = 0; k < 256; k++) pal[k] = vw(ADDR_W'(17'h05000 + k));
    sweep(0, 255, "R6 fill completes after hand-served entries");

    // R7 / R9: window 10..14, step every second frame
    cfg(1, 10);
    cfg(2, 14);
    cfg(3, 2);
    sweep(0, 31, "R7 window before any frame");
    for (int f = 0; f < 12; f++) begin
      tick();
      sweep(0, 31, "R9 rotation after frame pulse");
    end

    // R7: whole palette rotating every frame
    cfg(1, 0);
    cfg(2, 255);
    cfg(3, 1);
    for (int f = 0; f < 3; f++) tick();
    sweep(0, 255, "R7 full-range rotation");

    // R10: rate zero clears and holds the offset
    cfg(3, 0);
    tick();
    tick();
    sweep(0, 255, "R10 rate zero identity");
    cfg(3, 1);
    tick();
    sweep(0, 7, "R9 one step at rate one");
    cfg(1, 0);
    sweep(0, 7, "R10 window write clears offset");

    // R8: empty window and indices outside a small window
    cfg(1, 20);
    cfg(2, 5);
    cfg(3, 1);
    for (int f = 0; f < 3; f++) tick();
    sweep(0, 31, "R8 empty window passes through");
    cfg(1, 100);
    cfg(2, 103);
    tick();
    sweep(90, 110, "R8 outside window unchanged");

    idle(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule